// File: doc/BRIEF.md
# Keyed-Access Watchdog Timer

This block is a watchdog peripheral on a small register bus with three word registers: control/status at word address 0, counter at word address 1 and timeout at word address 2. Software arms it by writing a 32-bit open key to the counter address. That write opens a reconfiguration window of 128 bus cycles. While the window is open, software may write the timeout register and the control register. Writing the control register commits the configuration and closes the window. A second 32-bit key, written to the same counter address, restarts the count. That is how software services the watchdog.

Once enabled, the counter advances on a selectable tick: every bus cycle, or one of three external tick strobes. When the count reaches the programmed timeout, the block asks the system for a reset. If the interrupt is enabled, it first raises an interrupt flag and allows a fixed grace period before the reset request.

Other events also raise the reset request at once:
- a wrong value written to the counter address;
- a restart that arrives too early while window mode is on.

A debug-run bit decides whether counting pauses while the core reports a debug halt. An update-allow bit decides whether the configuration can ever be opened again.

Top module: `kwdog_top`

## Requirements
- R1: After reset, control reads 0x0000_0020, timeout reads 0x0000_FFFF, the counter reads 0, and both `irq` and `rst_req` are low. Control bit layout: [0] enable, [2:1] tick select, [3] interrupt enable, [4] window mode, [5] update allow, [6] debug run, [8] interrupt flag, [9] unlocked, [10] configuration done.
- R2: Writing 0xD928C520 to the counter address sets control bit 9 (unlocked) in the next cycle and leaves the count unchanged. The count keeps advancing on that cycle as it would otherwise.
- R3: Writes to the timeout and control registers are accepted only while the block is unlocked. The unlocked state lasts for the 128 cycles that follow the open-key write. A write in the 128th following cycle is accepted; a write in the 129th is ignored.
- R4: An accepted control write takes effect in the next cycle. In that cycle bit 9 reads 0 and bit 10 reads 1. Bit 10 clears on the next accepted open key.
- R5: If a committed control value has bit 5 at 0, later open-key writes leave bit 9 at 0, and timeout writes have no effect until reset.
- R6: While enabled, the counter adds one on each selected tick and stops when it equals timeout bits [15:0]. The counter address reads the live count. Tick select 0 means every cycle; select k (1 to 3) means `src_tick[k-1]`.
- R7: Writing 0xB480A602 to the counter address clears the count to 0 in the next cycle.
- R8: With the interrupt disabled, `rst_req` rises in the cycle after the count first equals the timeout.
- R9: With the interrupt enabled, bit 8 and `irq` rise in the cycle after the count equals the timeout. `rst_req` rises exactly 128 cycles after that. Writing a 1 to control bit 8 clears the flag at any time, even while locked.
- R10: While enabled, writing any value other than the two keys to the counter address raises `rst_req` in the next cycle. While disabled, such a write has no effect.
- R11: With window mode on, a restart key written while the count is below timeout bits [31:16] raises `rst_req`. A restart key written at or above that bound only clears the count.
- R12: While `dbg_halt` is high and bit 6 is 0, the count holds. With bit 6 set, it keeps advancing.
- R13: Once raised, `rst_req` stays high until `rst_n` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 2 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| src_tick | input | 3 | External tick strobes selectable as count source |
| dbg_halt | input | 1 | Core reports a debug halt |
| irq | output | 1 | Timeout interrupt (flag AND enable) |
| rst_req | output | 1 | Sticky reset request to the system |

## Verification
Two situations are hardest to reach from the ports. The first is the exact edge of the reconfiguration window. The bench opens the window, idles an exact number of cycles, and writes the timeout register on the last accepted cycle and on the first rejected one, in separate sessions. The second is the interrupt-then-reset timeline. The bench programs a short random timeout, finds the cycle where `irq` rises, clears the flag, and then samples `rst_req` on both sides of the 128-cycle point. Random timeouts, run lengths and tick patterns come from a seeded generator, and bench functions predict the count and the reset level for each case.

// File: rtl/kwdog_pkg.sv
package kwdog_pkg;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_CNT  = 2'd1;
  localparam logic [1:0] A_TOV  = 2'd2;

  typedef struct packed {
    logic       dbg_run;
    logic       allow_upd;
    logic       win_en;
    logic       irq_en;
    logic [1:0] csel;
    logic       en;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{dbg_run: 1'b0, allow_upd: 1'b1, win_en: 1'b0,
                                 irq_en: 1'b0, csel: 2'd0, en: 1'b0};

  function automatic logic [31:0] ctrl_image(ctrl_t c, logic flag, logic unl, logic done);
    return {21'd0, done, unl, flag, 1'b0, c};
  endfunction

  function automatic logic early_kick(logic win_on, logic [15:0] cnt, logic [15:0] lo);
    return win_on && (cnt < lo);
  endfunction

endpackage

// File: rtl/kwdog_keygate.sv
module kwdog_keygate #(
  parameter int WIN_CYC = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic open_req,
  input  logic lockout,
  input  logic commit,
  output logic unlocked
);
  localparam int WW = $clog2(WIN_CYC);
  localparam logic [WW-1:0] LAST = WW'(WIN_CYC - 1);

  logic [WW-1:0] wcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked <= 1'b0;
      wcnt     <= '0;
    end else if (open_req && !lockout) begin
      unlocked <= 1'b1;
      wcnt     <= '0;
    end else if (unlocked) begin
      if (commit || wcnt == LAST) unlocked <= 1'b0;
      else                        wcnt     <= wcnt + 1'b1;
    end
  end
endmodule

// File: rtl/kwdog_count.sv
module kwdog_count #(
  parameter int CNT_W = 16,
  parameter int NSRC  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [1:0]       csel,
  input  logic [NSRC-1:0]  src_tick,
  input  logic             dbg_halt,
  input  logic             dbg_run,
  input  logic [CNT_W-1:0] toval,
  input  logic             clear,
  output logic [CNT_W-1:0] cnt,
  output logic             at_top
);
  logic tick, run;

  always_comb begin
    tick = (csel == 2'd0);
    for (int i = 0; i < NSRC; i++)
      if (csel == 2'(i + 1)) tick = src_tick[i];
  end

  assign at_top = (cnt == toval);
  assign run    = en && tick && !at_top && (!dbg_halt || dbg_run);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (run)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/kwdog_alarm.sv
module kwdog_alarm #(
  parameter int GRACE_CYC = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic irq_en,
  input  logic kick,
  input  logic violation,
  input  logic irq_clr,
  output logic irq_flag,
  output logic rst_req
);
  localparam int GW = $clog2(GRACE_CYC);
  localparam logic [GW-1:0] GLAST = GW'(GRACE_CYC - 1);

  logic          grace_on;
  logic [GW-1:0] gcnt;
  logic          irq_set, expire;

  assign irq_set = hit && !kick && !grace_on && irq_en;
  assign expire  = (hit && !kick && !grace_on && !irq_en) ||
                   (grace_on && !kick && gcnt == GLAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grace_on <= 1'b0;
      gcnt     <= '0;
    end else if (kick) begin
      grace_on <= 1'b0;
    end else if (irq_set) begin
      grace_on <= 1'b1;
      gcnt     <= '0;
    end else if (grace_on && gcnt != GLAST) begin
      gcnt <= gcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq_flag <= 1'b0;
    else if (irq_set) irq_flag <= 1'b1;
    else if (irq_clr) irq_flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  rst_req <= 1'b0;
    else if (violation || expire) rst_req <= 1'b1;
  end
endmodule

// File: rtl/kwdog_top.sv
module kwdog_top
  import kwdog_pkg::*;
#(
  parameter int          CNT_W      = 16,
  parameter int          NSRC       = 3,
  parameter int          WIN_CYC    = 128,
  parameter int          GRACE_CYC  = 128,
  parameter logic [31:0] KEY_OPEN   = 32'hD928C520,
  parameter logic [31:0] KEY_KICK   = 32'hB480A602
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic [1:0]      bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  input  logic [NSRC-1:0] src_tick,
  input  logic            dbg_halt,
  output logic            irq,
  output logic            rst_req
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] toval_q, winlo_q, cnt;
  logic             cfg_lock_q, cfg_done_q, unlocked, at_top, irq_flag;

  // named bus events
  logic wr_ctrl, wr_cnt, wr_tov;
  logic open_ev, open_acc, kick_ev, bad_key_ev, early_ev, commit_ev, tov_acc, irq_clr;

  assign wr_ctrl    = bus_sel && bus_wr && bus_addr == A_CTRL;
  assign wr_cnt     = bus_sel && bus_wr && bus_addr == A_CNT;
  assign wr_tov     = bus_sel && bus_wr && bus_addr == A_TOV;
  assign open_ev    = wr_cnt && bus_wdata == KEY_OPEN;
  assign open_acc   = open_ev && !cfg_lock_q;
  assign kick_ev    = wr_cnt && bus_wdata == KEY_KICK;
  assign bad_key_ev = wr_cnt && !open_ev && !kick_ev && ctrl_q.en;
  assign early_ev   = kick_ev && ctrl_q.en &&
                      early_kick(ctrl_q.win_en, 16'(cnt), 16'(winlo_q));
  assign commit_ev  = wr_ctrl && unlocked;
  assign tov_acc    = wr_tov && unlocked;
  assign irq_clr    = wr_ctrl && bus_wdata[8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= CTRL_RST;
      toval_q    <= '1;
      winlo_q    <= '0;
      cfg_lock_q <= 1'b0;
      cfg_done_q <= 1'b0;
    end else begin
      if (tov_acc) begin
        toval_q <= bus_wdata[CNT_W-1:0];
        winlo_q <= bus_wdata[16 +: CNT_W];
      end
      if (commit_ev) begin
        ctrl_q     <= ctrl_t'(bus_wdata[6:0]);
        cfg_lock_q <= !bus_wdata[5];
        cfg_done_q <= 1'b1;
      end else if (open_acc) begin
        cfg_done_q <= 1'b0;
      end
    end
  end

  kwdog_keygate #(.WIN_CYC(WIN_CYC)) u_gate (
    .clk(clk), .rst_n(rst_n), .open_req(open_ev), .lockout(cfg_lock_q),
    .commit(commit_ev), .unlocked(unlocked)
  );

  kwdog_count #(.CNT_W(CNT_W), .NSRC(NSRC)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(ctrl_q.en), .csel(ctrl_q.csel),
    .src_tick(src_tick), .dbg_halt(dbg_halt), .dbg_run(ctrl_q.dbg_run),
    .toval(toval_q), .clear(kick_ev), .cnt(cnt), .at_top(at_top)
  );

  kwdog_alarm #(.GRACE_CYC(GRACE_CYC)) u_alarm (
    .clk(clk), .rst_n(rst_n), .hit(ctrl_q.en && at_top), .irq_en(ctrl_q.irq_en),
    .kick(kick_ev), .violation(bad_key_ev || early_ev), .irq_clr(irq_clr),
    .irq_flag(irq_flag), .rst_req(rst_req)
  );

  assign irq = irq_flag && ctrl_q.irq_en;

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = ctrl_image(ctrl_q, irq_flag, unlocked, cfg_done_q);
      A_CNT:   bus_rdata = 32'(cnt);
      A_TOV:   bus_rdata = (32'(winlo_q) << 16) | 32'(toval_q);
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/kwdog_chk.sv
module kwdog_chk #(
  parameter int CNT_W   = 16,
  parameter int WIN_CYC = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             unlocked,
  input logic             open_acc,
  input logic             commit_ev,
  input logic             cfg_done_q,
  input logic             kick_ev,
  input logic             bad_key_ev,
  input logic [CNT_W-1:0] cnt,
  input logic             en,
  input logic             dbg_halt,
  input logic             dbg_run,
  input logic             rst_req
);
  logic [$clog2(WIN_CYC+1):0] ucnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ucnt <= '0;
    else if (open_acc) ucnt <= '0;
    else if (unlocked) ucnt <= ucnt + 1'b1;
    else               ucnt <= '0;
  end

  a_r3_window_len: assert property (@(posedge clk) disable iff (!rst_n)
    unlocked |-> ucnt < WIN_CYC);
  a_r4_commit_closes: assert property (@(posedge clk) disable iff (!rst_n)
    commit_ev |=> (!unlocked && cfg_done_q));
  a_r7_kick_clears: assert property (@(posedge clk) disable iff (!rst_n)
    kick_ev |=> cnt == '0);
  a_r10_bad_key: assert property (@(posedge clk) disable iff (!rst_n)
    bad_key_ev |=> rst_req);
  a_r12_halt_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (en && dbg_halt && !dbg_run && !kick_ev) |=> $stable(cnt));
  a_r6_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !kick_ev |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));
  a_r13_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req);
endmodule

bind kwdog_top kwdog_chk #(.CNT_W(CNT_W), .WIN_CYC(WIN_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .unlocked(unlocked), .open_acc(open_acc),
  .commit_ev(commit_ev), .cfg_done_q(cfg_done_q), .kick_ev(kick_ev),
  .bad_key_ev(bad_key_ev), .cnt(cnt), .en(ctrl_q.en), .dbg_halt(dbg_halt),
  .dbg_run(ctrl_q.dbg_run), .rst_req(rst_req)
);

// File: tb/kwdog_top_tb.sv
module kwdog_top_tb;
  localparam int CLK_P = 10;
  localparam logic [31:0] K_OPEN = 32'hD928C520;
  localparam logic [31:0] K_KICK = 32'hB480A602;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [2:0]  src_tick = '0;
  logic        dbg_halt = 1'b0, irq, rst_req;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  kwdog_top u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_tick(src_tick), .dbg_halt(dbg_halt), .irq(irq), .rst_req(rst_req)
  );

  function automatic logic [31:0] cword(bit en, bit [1:0] cs, bit ie, bit we, bit up, bit dr);
    return {25'd0, dr, up, we, ie, cs, en};
  endfunction
  function automatic int exp_count(int n, int tov);
    return (n < tov) ? n : tov;
  endfunction
  function automatic bit exp_reset(int n, int tov);
    return n >= tov + 1;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(logic [1:0] a, logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask
  task automatic rd(logic [1:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask
  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic do_reset();
    rst_n = 1'b0; dbg_halt = 1'b0; src_tick = '0;
    idle(3); rst_n = 1'b1; idle(1);
  endtask
  task automatic setup(logic [15:0] tov, logic [15:0] lo, logic [31:0] cw);
    wr(2'd1, K_OPEN); wr(2'd2, {lo, tov}); wr(2'd0, cw);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd4242));
    do_reset();

    // R1 reset state
    rd(2'd0, v); check("R1 ctrl", v, 32'h20);
    rd(2'd2, v); check("R1 tov", v, 32'hFFFF);
    rd(2'd1, v); check("R1 cnt", v, 0);
    check("R1 outs", {irq, rst_req}, 0);

    // R10 disabled: foreign value ignored
    wr(2'd1, 32'h1234_5678); check("R10 disabled", rst_req, 0);
    // R3 locked writes ignored
    wr(2'd2, 32'h0000_1234); rd(2'd2, v); check("R3 locked tov", v, 32'hFFFF);
    wr(2'd0, cword(1,0,0,0,1,0)); rd(2'd0, v); check("R3 locked ctrl", v, 32'h20);

    // R2/R3 window edges
    wr(2'd1, K_OPEN); rd(2'd0, v); check("R2 unlocked bit", v[9], 1);
    rd(2'd1, v); check("R2 no load", v, 0);
    idle(127); wr(2'd2, 32'h0005_0077);
    rd(2'd2, v); check("R3 last cycle accepted", v, 32'h0005_0077);
    rd(2'd0, v); check("R3 closed", v[9], 0);
    wr(2'd1, K_OPEN); idle(128); wr(2'd2, 32'h0000_0011);
    rd(2'd2, v); check("R3 late rejected", v, 32'h0005_0077);

    // R4 commit
    wr(2'd1, K_OPEN); rd(2'd0, v); check("R4 done cleared on open", v[10], 0);
    wr(2'd0, cword(0,2'd2,1,1,1,1)); rd(2'd0, v);
    check("R4 commit image", v, 32'h400 | cword(0,2'd2,1,1,1,1));

    // R5 write-once
    do_reset();
    setup(16'd100, 16'd0, cword(0,0,0,0,0,0));
    wr(2'd1, K_OPEN); rd(2'd0, v); check("R5 open ignored", v[9], 0);
    wr(2'd2, 32'h33); rd(2'd2, v); check("R5 tov frozen", v, 100);

    // R6/R8 random run lengths on the bus clock
    for (int it = 0; it < 5; it++) begin
      int tov, n;
      tov = 5 + int'($urandom_range(0, 40));
      n   = 1 + int'($urandom_range(0, 60));
      do_reset();
      setup(16'(tov), 16'd0, cword(1,0,0,0,1,0));
      idle(n);
      rd(2'd1, v); check("R6 count", v, 32'(exp_count(n, tov)));
      check("R8 reset level", rst_req, exp_reset(n, tov));
    end
    do_reset();
    setup(16'd9, 16'd0, cword(1,0,0,0,1,0));
    idle(9); check("R8 not yet", rst_req, 0);
    idle(1); check("R8 fired", rst_req, 1);
    wr(2'd1, K_KICK); idle(3); check("R13 sticky", rst_req, 1);

    // R6 external tick select
    begin
      int ones = 0;
      do_reset();
      setup(16'd1000, 16'd0, cword(1,2'd1,0,0,1,0));
      for (int i = 0; i < 40; i++) begin
        logic [2:0] t;
        t = 3'($urandom_range(0, 7));
        src_tick = t; ones += int'(t[0]);
        @(negedge clk);
      end
      src_tick = '0; idle(1);
      rd(2'd1, v); check("R6 tick source", v, 32'(ones));
    end

    // R7 restart and R2 open while running
    do_reset();
    setup(16'd1000, 16'd0, cword(1,0,0,0,1,0));
    idle(17); rd(2'd1, v); check("R6 live", v, 17);
    wr(2'd1, K_OPEN); rd(2'd1, v); check("R2 count untouched", v, 18);
    wr(2'd1, K_KICK); rd(2'd1, v); check("R7 cleared", v, 0);
    idle(5); rd(2'd1, v); check("R7 recount", v, 5);

    // R10 foreign value while enabled
    wr(2'd1, $urandom() | 32'h1); check("R10 bad key", rst_req, 1);

    // R11 window mode
    do_reset();
    setup(16'd500, 16'd20, cword(1,0,0,1,1,0));
    idle(30); wr(2'd1, K_KICK); check("R11 late kick ok", rst_req, 0);
    rd(2'd1, v); check("R11 cleared", v, 0);
    idle(10); wr(2'd1, K_KICK); check("R11 early kick", rst_req, 1);

    // R9 interrupt then reset
    begin
      int t;
      t = 4 + int'($urandom_range(0, 20));
      do_reset();
      setup(16'(t), 16'd0, cword(1,0,1,0,1,0));
      idle(t); check("R9 irq not yet", irq, 0);
      idle(1); check("R9 irq raised", irq, 1);
      rd(2'd0, v); check("R9 flag bit", v[8], 1);
      wr(2'd0, 32'h100); check("R9 w1c", irq, 0);
      idle(126); check("R9 grace holds", rst_req, 0);
      idle(1); check("R9 grace ends", rst_req, 1);
    end

    // R12 debug halt
    do_reset();
    setup(16'd1000, 16'd0, cword(1,0,0,0,1,0));
    idle(5); dbg_halt = 1'b1; idle(10);
    rd(2'd1, v); check("R12 frozen", v, 5);
    do_reset();
    setup(16'd1000, 16'd0, cword(1,0,0,0,1,1));
    dbg_halt = 1'b1; idle(10);
    rd(2'd1, v); check("R12 runs", v, 10);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule